// File: doc/BRIEF.md
# Seven-Stage Pipeline Hazard Unit

This block resolves data and control hazards for an in-order 32-bit integer pipeline whose stages are, in order, fetch-1, fetch-2, decode, execute, memory-1, memory-2 and writeback. Fetch spans two stages because the instruction memory needs two cycles to return a word.

For each of the two execute-stage source registers, the block picks one operand value. It takes the youngest in-flight result from memory-1, memory-2 or writeback that targets that register. When no such result exists, it passes the register-file read through unchanged. This means dependent instructions can run back to back.

The block also handles three other cases:
- **Load-use hazard.** When an instruction in execute needs a load that is still in memory-1, the block holds fetch-1 through execute for one cycle and injects a bubble into memory-1.
- **Redirect.** When a jump or taken branch resolves in execute, the block flushes fetch-1, fetch-2 and decode and tells fetch to load the new PC.
- **Fetch-2 output.** It builds the fetch-2 output slot: either the fetched word, or the canonical bubble (the instruction word 0x00000013 with its bubble flag set).

The load-use control is a two-state machine:
- **RUN** is entered from reset. RUN moves to **LOAD_WAIT** on a load-use hit, and stays in RUN otherwise.
- **LOAD_WAIT** always returns to RUN on the next clock. During LOAD_WAIT the load sits in memory-2 and is forwarded from there.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When a memory-1 result has its write enable set, its bubble flag clear, is not a load, and its destination equals a nonzero execute source index, that operand output equals the memory-1 result.
- R2: When several stages match the same source index, priority is memory-1 over memory-2 over writeback. A stage whose write enable is clear or whose bubble flag is set never matches.
- R3: A source index of 0 always yields the register-file value, even when producers target register 0.
- R4: With no qualifying match, each operand output equals its register-file input.
- R5: In state RUN, a memory-1 load (write enable set, bubble clear, nonzero destination) whose destination equals either execute source index drives `hold_front` and `me1_inject` high in that cycle. The state becomes LOAD_WAIT.
- R6: When `ex_redirect` is high and no load-use hold is asserted, `flush_front` and `pc_load` are high in the same cycle.
- R7: A redirect that arrives during a load-use hold is deferred: `flush_front` stays low while `hold_front` is high.
- R8: `if2_nop` is 1 and `if2_instr` is 0x00000013 whenever a flush, an instruction-bus stall or a fetch-1 bubble is present. Otherwise `if2_nop` is 0 and `if2_instr` equals `ibus_rdata`.
- R9: The hold lasts exactly one cycle. In LOAD_WAIT, `hold_front` is low even if a matching load is still shown in memory-1, and the state returns to RUN at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_rs1 | input | 5 | Execute first source index |
| ex_rs2 | input | 5 | Execute second source index |
| rf_rs1_val | input | 32 | Register-file value for first source |
| rf_rs2_val | input | 32 | Register-file value for second source |
| me1_rd | input | 5 | Memory-1 destination index |
| me1_wen | input | 1 | Memory-1 write enable |
| me1_nop | input | 1 | Memory-1 bubble flag |
| me1_load | input | 1 | Memory-1 holds a load |
| me1_val | input | 32 | Memory-1 result |
| me2_rd | input | 5 | Memory-2 destination index |
| me2_wen | input | 1 | Memory-2 write enable |
| me2_nop | input | 1 | Memory-2 bubble flag |
| me2_val | input | 32 | Memory-2 result (load data included) |
| wb_rd | input | 5 | Writeback destination index |
| wb_wen | input | 1 | Writeback write enable |
| wb_nop | input | 1 | Writeback bubble flag |
| wb_val | input | 32 | Writeback result |
| ex_redirect | input | 1 | Jump or taken branch resolved in execute |
| ibus_stall | input | 1 | Instruction bus stall |
| ibus_rdata | input | 32 | Instruction bus data |
| if1_nop | input | 1 | Fetch-1 slot is a bubble |
| op_rs1 | output | 32 | Forwarded first operand |
| op_rs2 | output | 32 | Forwarded second operand |
| hold_front | output | 1 | Hold fetch-1 through execute registers |
| me1_inject | output | 1 | Load a bubble into memory-1 |
| flush_front | output | 1 | Kill fetch-1, fetch-2 and decode slots |
| pc_load | output | 1 | Load redirect target into fetch-1 |
| if2_instr | output | 32 | Next decode instruction word |
| if2_nop | output | 1 | Next decode bubble flag |

## Verification
The hardest case to reach from the ports is the LOAD_WAIT state meeting inputs that would trigger a second hold. The same applies to a redirect that collides with a load-use hold. Both depend on state the bench cannot set directly.

The stimulus first raises a matching memory-1 load in one cycle. On the following cycle it either keeps that load in place or adds a redirect. It then checks that the hold does not repeat and that the deferred flush arrives one cycle later.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam logic [31:0] NOP_WORD32 = 32'h0000_0013;

    typedef enum logic [0:0] {
        ST_RUN       = 1'b0,
        ST_LOAD_WAIT = 1'b1
    } hz_state_e;
endpackage

// File: rtl/hz_fwd_mux.sv
module hz_fwd_mux #(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int NSRC = 3
) (
    input  logic [RIDX-1:0]            src_idx,
    input  logic [XLEN-1:0]            rf_val,
    input  logic [NSRC-1:0]            p_ok,
    input  logic [NSRC-1:0][RIDX-1:0]  p_rd,
    input  logic [NSRC-1:0][XLEN-1:0]  p_val,
    output logic [XLEN-1:0]            op
);
    // Producer 0 is the youngest. Scanning from oldest to youngest lets the
    // youngest matching producer overwrite the others.
    always_comb begin
        op = rf_val;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (p_ok[k] && (p_rd[k] == src_idx) && (src_idx != '0)) begin
                op = p_val[k];
            end
        end
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] rs1,
    input  logic [RIDX-1:0] rs2,
    input  logic [RIDX-1:0] me1_rd,
    input  logic            me1_wen,
    input  logic            me1_nop,
    input  logic            me1_load,
    input  logic            ex_redirect,
    output logic            hold,
    output logic            inject,
    output logic            flush
);
    import hz_pkg::*;

    hz_state_e st, st_nxt;
    logic      ld_hit;

    assign ld_hit = me1_load && me1_wen && !me1_nop && (me1_rd != '0)
                    && ((me1_rd == rs1) || (me1_rd == rs2));

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        hold   = 1'b0;
        inject = 1'b0;
        flush  = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (ld_hit) begin
                    hold   = 1'b1;
                    inject = 1'b1;
                    st_nxt = ST_LOAD_WAIT;
                end else begin
                    flush  = ex_redirect;
                end
            end
            ST_LOAD_WAIT: begin
                flush  = ex_redirect;
                st_nxt = ST_RUN;
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    p_hold_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold);
    p_hold_defers_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !flush);
    p_redirect_flushes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_redirect && !hold) |-> flush);
    p_load_hit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hit && st == ST_RUN) |-> (hold && inject));
endmodule

// File: rtl/hz_if2_slot.sv
module hz_if2_slot #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ibus_rdata,
    input  logic            ibus_stall,
    input  logic            if1_nop,
    input  logic            flush,
    output logic [XLEN-1:0] instr,
    output logic            nop
);
    localparam logic [XLEN-1:0] NOP_W = XLEN'(hz_pkg::NOP_WORD32);

    always_comb begin
        if (flush || ibus_stall || if1_nop) begin
            instr = NOP_W;
            nop   = 1'b1;
        end else begin
            instr = ibus_rdata;
            nop   = 1'b0;
        end
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] ex_rs1,
    input  logic [RIDX-1:0] ex_rs2,
    input  logic [XLEN-1:0] rf_rs1_val,
    input  logic [XLEN-1:0] rf_rs2_val,
    input  logic [RIDX-1:0] me1_rd,
    input  logic            me1_wen,
    input  logic            me1_nop,
    input  logic            me1_load,
    input  logic [XLEN-1:0] me1_val,
    input  logic [RIDX-1:0] me2_rd,
    input  logic            me2_wen,
    input  logic            me2_nop,
    input  logic [XLEN-1:0] me2_val,
    input  logic [RIDX-1:0] wb_rd,
    input  logic            wb_wen,
    input  logic            wb_nop,
    input  logic [XLEN-1:0] wb_val,
    input  logic            ex_redirect,
    input  logic            ibus_stall,
    input  logic [XLEN-1:0] ibus_rdata,
    input  logic            if1_nop,
    output logic [XLEN-1:0] op_rs1,
    output logic [XLEN-1:0] op_rs2,
    output logic            hold_front,
    output logic            me1_inject,
    output logic            flush_front,
    output logic            pc_load,
    output logic [XLEN-1:0] if2_instr,
    output logic            if2_nop
);
    localparam int NSRC = 3;
    localparam int NOPS = 2;
    localparam logic [XLEN-1:0] NOP_W = XLEN'(hz_pkg::NOP_WORD32);

    logic [NSRC-1:0]           p_ok;
    logic [NSRC-1:0][RIDX-1:0] p_rd;
    logic [NSRC-1:0][XLEN-1:0] p_val;
    logic [NOPS-1:0][RIDX-1:0] src_idx;
    logic [NOPS-1:0][XLEN-1:0] src_rf;
    logic [NOPS-1:0][XLEN-1:0] src_op;
    logic                      flush_i;

    // A load in memory-1 has no data yet, so it is not a forwarding source.
    assign p_ok  = {wb_wen && !wb_nop, me2_wen && !me2_nop,
                    me1_wen && !me1_nop && !me1_load};
    assign p_rd  = {wb_rd, me2_rd, me1_rd};
    assign p_val = {wb_val, me2_val, me1_val};

    assign src_idx = {ex_rs2, ex_rs1};
    assign src_rf  = {rf_rs2_val, rf_rs1_val};

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        hz_fwd_mux #(.XLEN(XLEN), .RIDX(RIDX), .NSRC(NSRC)) u_mux (
            .src_idx (src_idx[g]),
            .rf_val  (src_rf[g]),
            .p_ok    (p_ok),
            .p_rd    (p_rd),
            .p_val   (p_val),
            .op      (src_op[g])
        );
    end

    assign op_rs1 = src_op[0];
    assign op_rs2 = src_op[1];

    hz_ctrl #(.RIDX(RIDX)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rs1         (ex_rs1),
        .rs2         (ex_rs2),
        .me1_rd      (me1_rd),
        .me1_wen     (me1_wen),
        .me1_nop     (me1_nop),
        .me1_load    (me1_load),
        .ex_redirect (ex_redirect),
        .hold        (hold_front),
        .inject      (me1_inject),
        .flush       (flush_i)
    );

    assign flush_front = flush_i;
    assign pc_load     = flush_i;

    hz_if2_slot #(.XLEN(XLEN)) u_if2 (
        .ibus_rdata (ibus_rdata),
        .ibus_stall (ibus_stall),
        .if1_nop    (if1_nop),
        .flush      (flush_i),
        .instr      (if2_instr),
        .nop        (if2_nop)
    );

    p_x0_uses_rf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (op_rs1 == rf_rs1_val));
    p_me1_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (me1_wen && !me1_nop && !me1_load && me1_rd != '0 && me1_rd == ex_rs1)
        |-> (op_rs1 == me1_val));
    p_bubble_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        if2_nop |-> (if2_instr == NOP_W));
    p_flush_bubbles_if2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_front |-> if2_nop);
endmodule

// File: tb/pipe_hazard_unit_tb_top.sv
module pipe_hazard_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ex_rs1, ex_rs2, me1_rd, me2_rd, wb_rd;
    logic [31:0] rf_rs1_val, rf_rs2_val, me1_val, me2_val, wb_val, ibus_rdata;
    logic        me1_wen, me1_nop, me1_load, me2_wen, me2_nop, wb_wen, wb_nop;
    logic        ex_redirect, ibus_stall, if1_nop;
    logic [31:0] op_rs1, op_rs2, if2_instr;
    logic        hold_front, me1_inject, flush_front, pc_load, if2_nop;

    int n_chk = 0;
    int n_err = 0;
    localparam logic [31:0] NOPW = 32'h0000_0013;

    always #10 clk = ~clk;

    pipe_hazard_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .rf_rs1_val(rf_rs1_val), .rf_rs2_val(rf_rs2_val),
        .me1_rd(me1_rd), .me1_wen(me1_wen), .me1_nop(me1_nop),
        .me1_load(me1_load), .me1_val(me1_val),
        .me2_rd(me2_rd), .me2_wen(me2_wen), .me2_nop(me2_nop), .me2_val(me2_val),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_nop(wb_nop), .wb_val(wb_val),
        .ex_redirect(ex_redirect), .ibus_stall(ibus_stall),
        .ibus_rdata(ibus_rdata), .if1_nop(if1_nop),
        .op_rs1(op_rs1), .op_rs2(op_rs2), .hold_front(hold_front),
        .me1_inject(me1_inject), .flush_front(flush_front), .pc_load(pc_load),
        .if2_instr(if2_instr), .if2_nop(if2_nop)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        ex_rs1 = 5'd1; ex_rs2 = 5'd2;
        rf_rs1_val = 32'hAAAA_0001; rf_rs2_val = 32'hAAAA_0002;
        me1_rd = 5'd0; me1_wen = 0; me1_nop = 1; me1_load = 0; me1_val = 32'h1111_1111;
        me2_rd = 5'd0; me2_wen = 0; me2_nop = 1; me2_val = 32'h2222_2222;
        wb_rd = 5'd0;  wb_wen = 0;  wb_nop = 1;  wb_val = 32'h3333_3333;
        ex_redirect = 0; ibus_stall = 0; ibus_rdata = 32'h00A0_0093; if1_nop = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        #2;
        chk("R4 reset op_rs1", op_rs1, rf_rs1_val);
        chk("R4 reset op_rs2", op_rs2, rf_rs2_val);
        chk("R6 reset flush", {31'd0, flush_front}, 32'd0);
        chk("R5 reset hold", {31'd0, hold_front}, 32'd0);
    endtask

    task automatic t_fwd_me1();
        step(); idle();
        ex_rs1 = 5'd3; me1_rd = 5'd3; me1_wen = 1; me1_nop = 0; #2;
        chk("R1 me1 to rs1", op_rs1, me1_val);
        chk("R4 rs2 unmatched", op_rs2, rf_rs2_val);
        ex_rs1 = 5'd1; ex_rs2 = 5'd3; #2;
        chk("R1 me1 to rs2", op_rs2, me1_val);
    endtask

    task automatic t_priority();
        step(); idle();
        ex_rs1 = 5'd7;
        me1_rd = 5'd7; me1_wen = 1; me1_nop = 0;
        me2_rd = 5'd7; me2_wen = 1; me2_nop = 0;
        wb_rd  = 5'd7; wb_wen  = 1; wb_nop  = 0; #2;
        chk("R2 me1 wins", op_rs1, me1_val);
        me1_nop = 1; #2;
        chk("R2 me2 over wb", op_rs1, me2_val);
        me2_wen = 0; #2;
        chk("R2 wb last", op_rs1, wb_val);
        wb_nop = 1; #2;
        chk("R2 bubble wb ignored", op_rs1, rf_rs1_val);
    endtask

    task automatic t_x0();
        step(); idle();
        ex_rs1 = 5'd0; ex_rs2 = 5'd0;
        me1_rd = 5'd0; me1_wen = 1; me1_nop = 0;
        me2_rd = 5'd0; me2_wen = 1; me2_nop = 0; #2;
        chk("R3 x0 rs1", op_rs1, rf_rs1_val);
        chk("R3 x0 rs2", op_rs2, rf_rs2_val);
    endtask

    task automatic t_gate();
        step(); idle();
        ex_rs1 = 5'd9; me1_rd = 5'd9; me1_wen = 0; me1_nop = 0; #2;
        chk("R4 wen low", op_rs1, rf_rs1_val);
        me1_wen = 1; me1_nop = 1; #2;
        chk("R4 bubble", op_rs1, rf_rs1_val);
    endtask

    task automatic t_load();
        step(); idle();
        ex_rs2 = 5'd12; me1_rd = 5'd12; me1_wen = 1; me1_nop = 0; me1_load = 1; #2;
        chk("R5 hold", {31'd0, hold_front}, 32'd1);
        chk("R5 inject", {31'd0, me1_inject}, 32'd1);
        step();
        me1_nop = 1; me1_load = 0; me1_wen = 0;
        me2_rd = 5'd12; me2_wen = 1; me2_nop = 0; me2_val = 32'hDEAD_BEEF; #2;
        chk("R9 hold released", {31'd0, hold_front}, 32'd0);
        chk("R5 load from me2", op_rs2, 32'hDEAD_BEEF);
        step(); idle();
        ex_rs1 = 5'd14; me1_rd = 5'd14; me1_wen = 1; me1_nop = 0; me1_load = 1; #2;
        chk("R5 hold rs1", {31'd0, hold_front}, 32'd1);
        step(); #2;
        chk("R9 no second hold", {31'd0, hold_front}, 32'd0);
        step(); #2;
        chk("R9 back to run", {31'd0, hold_front}, 32'd1);
        step(); idle(); step();
    endtask

    task automatic t_redirect();
        step(); idle();
        ex_redirect = 1; #2;
        chk("R6 flush", {31'd0, flush_front}, 32'd1);
        chk("R6 pc_load", {31'd0, pc_load}, 32'd1);
        chk("R8 flushed word", if2_instr, NOPW);
        chk("R8 flushed flag", {31'd0, if2_nop}, 32'd1);
    endtask

    task automatic t_defer();
        step(); idle();
        ex_rs1 = 5'd5; me1_rd = 5'd5; me1_wen = 1; me1_nop = 0; me1_load = 1;
        ex_redirect = 1; #2;
        chk("R7 flush deferred", {31'd0, flush_front}, 32'd0);
        chk("R7 hold active", {31'd0, hold_front}, 32'd1);
        step();
        me1_load = 0; me1_nop = 1; #2;
        chk("R7 flush after hold", {31'd0, flush_front}, 32'd1);
        step(); idle();
    endtask

    task automatic t_if2();
        step(); idle(); #2;
        chk("R8 pass data", if2_instr, 32'h00A0_0093);
        chk("R8 pass flag", {31'd0, if2_nop}, 32'd0);
        ibus_stall = 1; #2;
        chk("R8 stall word", if2_instr, NOPW);
        chk("R8 stall flag", {31'd0, if2_nop}, 32'd1);
        ibus_stall = 0; if1_nop = 1; #2;
        chk("R8 if1 bubble", if2_instr, NOPW);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle();
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_fwd_me1();
        t_priority();
        t_x0();
        t_gate();
        t_load();
        t_redirect();
        t_defer();
        t_if2();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule